// File: doc/BRIEF.md
# Domain-Tagged Page Permission Cache with Selective Fence

This block keeps a small, fully associative set of recently used physical-page access permissions (read, write, execute) on behalf of one hart. Each entry is tagged with a supervisor domain identifier, a page number and a mapping span, which is one of four sizes. A lookup port returns whether a domain/page pair is covered by a cached entry and, if so, its permission bits. A fill port writes a new entry into the slot named by a round-robin victim pointer.

A fence command port takes the two register indices of a fence or fine-grained invalidate instruction, the register values and the current privilege level. Both instruction forms use this port and behave the same. Which entries are dropped depends on which of the two indices name the zero register. Address matching uses each entry's own span. Only the implemented low bits of the domain operand take part in the compare. A fence issued below machine level raises an illegal-instruction flag and changes nothing. Two parameters let an implementation ignore the address operand, the domain operand or both, which makes the fence wider but still correct.

Top module: `dom_perm_cache`

## Requirements
- R1: After reset no entry is valid, every lookup misses, `fc_illegal` is low and the victim pointer names slot 0.
- R2: `lk_hit` is high in the same cycle when a valid entry has a domain equal to `lk_sdid` and a span that contains `lk_page`. `lk_perm` then gives that entry's bits (bit0 read, bit1 write, bit2 execute). If several entries match, the lowest slot index wins. `lk_perm` is 0 on a miss.
- R3: The span code is 0 for 4 KiB, 1 for 2 MiB, 2 for 4 MiB and 3 for 1 GiB. An entry covers the naturally aligned region of its span that contains its stored page, for lookups and for fence address matching alike.
- R4: Each fill writes the slot named by the victim pointer. The pointer starts at 0, moves up by one on every fill, returns to 0 after ENTRIES-1, and holds when there is no fill.
- R5: A legal fence whose two register indices are both 0 invalidates every entry of every domain.
- R6: A legal fence with rs1 index 0 and a non-zero rs2 index invalidates only the entries whose domain equals the rs2 domain value.
- R7: A legal fence with a non-zero rs1 index and rs2 index 0 invalidates, in all domains, the entries whose span contains the page of the rs1 address (address bits PA_W-1 down to 12).
- R8: A legal fence with both indices non-zero invalidates only the entries that match both the address and the domain.
- R9: Only rs2 bits SDID_LEN-1 down to 0 form the fence domain. Higher bits of rs2 have no effect.
- R10: The zero-register decision uses the register index, not the value. A non-zero index with value 0 selects address 0 or domain 0. Index 0 ignores the value.
- R11: Privilege code 3 is machine level. A fence at any other level raises `fc_illegal` in the same cycle and invalidates nothing.
- R12: Invalidation takes effect at the clock edge that ends the fence cycle. A lookup in the fence cycle misses on entries being invalidated. A fill in the same cycle is written after the invalidation, so the new entry survives.
- R13: With USE_ADDR=0 the address operand is treated as absent. With USE_SDID=0 the domain operand is treated as absent. With both at 0, every legal fence clears the whole cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_page | input | PA_W-12 | Lookup page number |
| lk_sdid | input | SDID_LEN | Lookup domain |
| lk_hit | output | 1 | Lookup covered by a valid entry |
| lk_perm | output | 3 | Permission bits of the winning entry |
| fill_valid | input | 1 | Write a new entry this cycle |
| fill_page | input | PA_W-12 | Page number of the new entry |
| fill_sdid | input | SDID_LEN | Domain of the new entry |
| fill_span | input | 2 | Span code of the new entry |
| fill_perm | input | 3 | Permission bits of the new entry |
| fc_valid | input | 1 | Fence command present |
| fc_rs1_idx | input | 5 | Address operand register index |
| fc_rs1_val | input | XLEN | Address operand value |
| fc_rs2_idx | input | 5 | Domain operand register index |
| fc_rs2_val | input | XLEN | Domain operand value |
| fc_priv | input | 2 | Privilege level of the command |
| fc_illegal | output | 1 | Fence issued below machine level |

## Verification
The bench fills the cache with entries that use all four spans and several domains, and places one small entry inside a large one from the same domain. It then probes each entry at its first page, its last page, the page just past its end and with a wrong domain, after every kind of fence. A design that compared whole page numbers would miss inside large spans. A design that ignored the span alignment would hit past the end. Wrong fill order or wrong priority would return the nested entry's permissions. The bench sets garbage in ignored operand bits, uses x0 indices with non-zero values and non-zero indices with zero values, and issues fences below machine level. These catch a decoder that tests values instead of indices, one that compares upper domain bits, or one that invalidates on an illegal command. A fence and a fill in the same cycle, with a lookup on a doomed entry, expose wrong update order or a registered kill.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    SPAN_4K = 2'd0,
    SPAN_2M = 2'd1,
    SPAN_4M = 2'd2,
    SPAN_1G = 2'd3
  } span_e;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  typedef struct packed {
    logic active;   // legal fence this cycle
    logic by_addr;  // restrict to entries covering the address
    logic by_sdid;  // restrict to one domain
  } kill_ctl_t;

  // number of low page-number bits ignored for a given span
  function automatic int unsigned span_shift(span_e s);
    case (s)
      SPAN_4K: span_shift = 0;
      SPAN_2M: span_shift = 9;
      SPAN_4M: span_shift = 10;
      default: span_shift = 18;
    endcase
  endfunction

endpackage

// File: rtl/dpc_fence_dec.sv
module dpc_fence_dec #(
  parameter int XLEN     = 64,
  parameter int PA_W     = 34,
  parameter int SDID_LEN = 4,
  parameter bit USE_ADDR = 1'b1,
  parameter bit USE_SDID = 1'b1,
  localparam int PN_W    = PA_W - 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fc_valid,
  input  logic [4:0]               rs1_idx,
  input  logic [XLEN-1:0]          rs1_val,
  input  logic [4:0]               rs2_idx,
  input  logic [XLEN-1:0]          rs2_val,
  input  logic [1:0]               priv,
  output logic                     illegal_o,
  output dpc_pkg::kill_ctl_t       kill_o,
  output logic [PN_W-1:0]          kill_pn_o,
  output logic [SDID_LEN-1:0]      kill_sdid_o
);
  import dpc_pkg::*;

  logic is_machine;
  logic addr_sel;
  logic sdid_sel;
  logic unused_operand_bits;

  assign is_machine = (priv == PRIV_MACHINE);

  generate
    if (USE_ADDR) begin : g_addr
      assign addr_sel = (rs1_idx != 5'd0);
    end else begin : g_no_addr
      assign addr_sel = 1'b0;
    end
    if (USE_SDID) begin : g_sdid
      assign sdid_sel = (rs2_idx != 5'd0);
    end else begin : g_no_sdid
      assign sdid_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    illegal_o      = fc_valid && !is_machine;
    kill_o.active  = fc_valid && is_machine;
    kill_o.by_addr = addr_sel;
    kill_o.by_sdid = sdid_sel;
  end

  assign kill_pn_o   = rs1_val[PA_W-1:12];
  assign kill_sdid_o = rs2_val[SDID_LEN-1:0];

  assign unused_operand_bits = ^{rs1_val[XLEN-1:PA_W], rs1_val[11:0],
                                 rs2_val[XLEN-1:SDID_LEN]};

  // R11: an illegal command never arms the invalidation
  assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !kill_o.active);

endmodule

// File: rtl/dpc_victim.sv
module dpc_victim #(
  parameter int ENTRIES = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  output logic [IW-1:0]      ptr_o,
  output logic [ENTRIES-1:0] sel_o
);

  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  assign ptr_en = adv;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
      assign sel_o[g] = (ptr_q == IW'(g));
    end
  endgenerate

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel_o));

endmodule

// File: rtl/dpc_entry.sv
module dpc_entry #(
  parameter int PN_W     = 22,
  parameter int SDID_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PN_W-1:0]      wr_pn,
  input  logic [SDID_LEN-1:0]  wr_sdid,
  input  dpc_pkg::span_e       wr_span,
  input  logic [2:0]           wr_perm,
  input  dpc_pkg::kill_ctl_t   kill,
  input  logic [PN_W-1:0]      kill_pn,
  input  logic [SDID_LEN-1:0]  kill_sdid,
  input  logic [PN_W-1:0]      lk_pn,
  input  logic [SDID_LEN-1:0]  lk_sdid,
  output logic                 valid_o,
  output logic                 hit_o,
  output logic [2:0]           perm_o,
  output logic                 doomed_o
);
  import dpc_pkg::*;

  logic                valid_q, valid_d;
  logic [PN_W-1:0]     pn_q;
  logic [SDID_LEN-1:0] sdid_q;
  span_e               span_q;
  logic [2:0]          perm_q;
  logic [PN_W-1:0]     cover_mask;
  logic                kill_addr_ok, kill_sdid_ok;

  always_comb begin
    cover_mask   = {PN_W{1'b1}} << span_shift(span_q);
    kill_addr_ok = !kill.by_addr || (((kill_pn ^ pn_q) & cover_mask) == '0);
    kill_sdid_ok = !kill.by_sdid || (kill_sdid == sdid_q);
    doomed_o     = valid_q && kill.active && kill_addr_ok && kill_sdid_ok;
    hit_o        = valid_q && !doomed_o && (lk_sdid == sdid_q) &&
                   (((lk_pn ^ pn_q) & cover_mask) == '0);
  end

  // fill is applied after invalidation
  always_comb begin
    valid_d = valid_q;
    if (doomed_o) valid_d = 1'b0;
    if (wr_en)    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pn_q   <= wr_pn;
      sdid_q <= wr_sdid;
      span_q <= wr_span;
      perm_q <= wr_perm;
    end
  end

  assign valid_o = valid_q;
  assign perm_o  = perm_q;

  assert_doomed_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    doomed_o && !wr_en |=> !valid_q);
  assert_fill_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q && (pn_q == $past(wr_pn)) && (sdid_q == $past(wr_sdid)));
  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> valid_q);

endmodule

// File: rtl/dom_perm_cache.sv
module dom_perm_cache #(
  parameter int ENTRIES  = 8,
  parameter int XLEN     = 64,
  parameter int PA_W     = 34,
  parameter int SDID_LEN = 4,
  parameter bit USE_ADDR = 1'b1,
  parameter bit USE_SDID = 1'b1,
  localparam int PN_W    = PA_W - 12,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PN_W-1:0]     lk_page,
  input  logic [SDID_LEN-1:0] lk_sdid,
  output logic                lk_hit,
  output logic [2:0]          lk_perm,
  input  logic                fill_valid,
  input  logic [PN_W-1:0]     fill_page,
  input  logic [SDID_LEN-1:0] fill_sdid,
  input  logic [1:0]          fill_span,
  input  logic [2:0]          fill_perm,
  input  logic                fc_valid,
  input  logic [4:0]          fc_rs1_idx,
  input  logic [XLEN-1:0]     fc_rs1_val,
  input  logic [4:0]          fc_rs2_idx,
  input  logic [XLEN-1:0]     fc_rs2_val,
  input  logic [1:0]          fc_priv,
  output logic                fc_illegal
);
  import dpc_pkg::*;

  kill_ctl_t           kill;
  logic [PN_W-1:0]     kill_pn;
  logic [SDID_LEN-1:0] kill_sdid;
  logic [IW-1:0]       vptr;
  logic [ENTRIES-1:0]  vsel;
  logic [ENTRIES-1:0]  valid_vec, hit_vec, doomed_vec;
  logic [2:0]          perm_arr [ENTRIES];

  dpc_fence_dec #(
    .XLEN(XLEN), .PA_W(PA_W), .SDID_LEN(SDID_LEN),
    .USE_ADDR(USE_ADDR), .USE_SDID(USE_SDID)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .fc_valid(fc_valid),
    .rs1_idx(fc_rs1_idx), .rs1_val(fc_rs1_val),
    .rs2_idx(fc_rs2_idx), .rs2_val(fc_rs2_val),
    .priv(fc_priv), .illegal_o(fc_illegal), .kill_o(kill),
    .kill_pn_o(kill_pn), .kill_sdid_o(kill_sdid)
  );

  dpc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(fill_valid), .ptr_o(vptr), .sel_o(vsel)
  );

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      dpc_entry #(.PN_W(PN_W), .SDID_LEN(SDID_LEN)) u_ent (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_valid && vsel[g]), .wr_pn(fill_page), .wr_sdid(fill_sdid),
        .wr_span(span_e'(fill_span)), .wr_perm(fill_perm),
        .kill(kill), .kill_pn(kill_pn), .kill_sdid(kill_sdid),
        .lk_pn(lk_page), .lk_sdid(lk_sdid),
        .valid_o(valid_vec[g]), .hit_o(hit_vec[g]), .perm_o(perm_arr[g]),
        .doomed_o(doomed_vec[g])
      );
    end
  endgenerate

  // lowest index wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_perm = 3'd0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lk_hit  = 1'b1;
        lk_perm = perm_arr[i];
      end
    end
  end

  assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid && (fc_priv == PRIV_MACHINE) && (fc_rs1_idx == 5'd0) &&
    (fc_rs2_idx == 5'd0) && !fill_valid |=> valid_vec == '0);
  assert_illegal_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fc_illegal && !fill_valid |=> valid_vec == $past(valid_vec));
  assert_fill_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> valid_vec[$past(vptr)]);
  assert_hit_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_vec & ~doomed_vec) != '0);
  assert_no_doom_when_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_valid |-> doomed_vec == '0);

endmodule

// File: tb/dom_perm_cache_test.sv
`timescale 1ns/1ps
module dom_perm_cache_test;

  localparam int N    = 8;
  localparam int XL   = 64;
  localparam int PA   = 34;
  localparam int SL   = 4;
  localparam int PN_W = PA - 12;

  logic            clk;
  logic            rst_n;
  logic [PN_W-1:0] lk_page;
  logic [SL-1:0]   lk_sdid;
  logic            lk_hit, gf_hit;
  logic [2:0]      lk_perm, gf_perm;
  logic            fill_valid;
  logic [PN_W-1:0] fill_page;
  logic [SL-1:0]   fill_sdid;
  logic [1:0]      fill_span;
  logic [2:0]      fill_perm;
  logic            fc_valid;
  logic [4:0]      fc_rs1_idx, fc_rs2_idx;
  logic [XL-1:0]   fc_rs1_val, fc_rs2_val;
  logic [1:0]      fc_priv;
  logic            fc_illegal, gf_illegal;

  int total = 0;
  int bad   = 0;

  dom_perm_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_page(lk_page), .lk_sdid(lk_sdid),
    .lk_hit(lk_hit), .lk_perm(lk_perm), .fill_valid(fill_valid),
    .fill_page(fill_page), .fill_sdid(fill_sdid), .fill_span(fill_span),
    .fill_perm(fill_perm), .fc_valid(fc_valid), .fc_rs1_idx(fc_rs1_idx),
    .fc_rs1_val(fc_rs1_val), .fc_rs2_idx(fc_rs2_idx), .fc_rs2_val(fc_rs2_val),
    .fc_priv(fc_priv), .fc_illegal(fc_illegal)
  );

  dom_perm_cache #(.USE_ADDR(1'b0), .USE_SDID(1'b0)) uut_gf (
    .clk(clk), .rst_n(rst_n), .lk_page(lk_page), .lk_sdid(lk_sdid),
    .lk_hit(gf_hit), .lk_perm(gf_perm), .fill_valid(fill_valid),
    .fill_page(fill_page), .fill_sdid(fill_sdid), .fill_span(fill_span),
    .fill_perm(fill_perm), .fc_valid(fc_valid), .fc_rs1_idx(fc_rs1_idx),
    .fc_rs1_val(fc_rs1_val), .fc_rs2_idx(fc_rs2_idx), .fc_rs2_val(fc_rs2_val),
    .fc_priv(fc_priv), .fc_illegal(gf_illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model
  bit      m_v    [N];
  longint  m_pn   [N];
  int      m_sd   [N];
  int      m_sp   [N];
  int      m_pm   [N];
  int      m_ptr;

  // fill table
  longint  t_pn [N];
  int      t_sd [N];
  int      t_sp [N];
  int      t_pm [N];

  function automatic int shf(int sp);
    case (sp)
      0: return 0;
      1: return 9;
      2: return 10;
      default: return 18;
    endcase
  endfunction

  function automatic bit covers(longint base, int sp, longint pn);
    return (base >> shf(sp)) == (pn >> shf(sp));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_fence(int i1, longint v1, int i2, longint v2, int pr);
    longint kpn;
    int     ks;
    if (pr != 3) return;
    kpn = (v1 >> 12) & ((64'd1 << PN_W) - 1);
    ks  = int'(v2 & ((64'd1 << SL) - 1));
    for (int i = 0; i < N; i++)
      if (m_v[i] && (i1 == 0 || covers(m_pn[i], m_sp[i], kpn)) &&
          (i2 == 0 || m_sd[i] == ks))
        m_v[i] = 1'b0;
  endtask

  task automatic model_fill(longint pn, int sd, int sp, int pm);
    m_v[m_ptr] = 1'b1; m_pn[m_ptr] = pn; m_sd[m_ptr] = sd;
    m_sp[m_ptr] = sp;  m_pm[m_ptr] = pm;
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic do_fill(longint pn, int sd, int sp, int pm);
    @(negedge clk);
    fill_valid = 1'b1; fill_page = PN_W'(pn); fill_sdid = SL'(sd);
    fill_span = 2'(sp); fill_perm = 3'(pm);
    @(posedge clk);
    model_fill(pn, sd, sp, pm);
    #1 fill_valid = 1'b0;
  endtask

  task automatic populate();
    for (int k = 0; k < N; k++) do_fill(t_pn[k], t_sd[k], t_sp[k], t_pm[k]);
  endtask

  task automatic do_fence(int i1, longint v1, int i2, longint v2, int pr, string req);
    @(negedge clk);
    fc_valid = 1'b1; fc_rs1_idx = 5'(i1); fc_rs1_val = v1;
    fc_rs2_idx = 5'(i2); fc_rs2_val = v2; fc_priv = 2'(pr);
    #1;
    chk(fc_illegal == (pr != 3), {"R11 illegal flag ", req}, fc_illegal, (pr != 3));
    @(posedge clk);
    model_fence(i1, v1, i2, v2, pr);
    #1 fc_valid = 1'b0;
  endtask

  task automatic expect_lookup(longint pn, int sd, output bit h, output int p);
    h = 1'b0; p = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_sd[i] == sd && covers(m_pn[i], m_sp[i], pn)) begin
        h = 1'b1; p = m_pm[i];
      end
  endtask

  task automatic look(longint pn, int sd, string req);
    bit eh;
    int ep;
    @(negedge clk);
    lk_page = PN_W'(pn); lk_sdid = SL'(sd);
    #1;
    expect_lookup(pn, sd, eh, ep);
    chk(lk_hit == eh, {req, " R2 hit"}, lk_hit, eh);
    chk(lk_perm == 3'(ep), {req, " R2 perm"}, lk_perm, ep);
  endtask

  // R3 boundaries: first page, last page, one past end, wrong domain
  task automatic sweep(string req);
    longint span;
    longint base;
    for (int k = 0; k < N; k++) begin
      span = 64'd1 << shf(t_sp[k]);
      base = (t_pn[k] >> shf(t_sp[k])) << shf(t_sp[k]);
      look(t_pn[k], t_sd[k], {req, " R3 own"});
      look(base + span - 1, t_sd[k], {req, " R3 last"});
      look(base + span, t_sd[k], {req, " R3 past"});
      look(t_pn[k], t_sd[k] ^ 1, {req, " R2 other dom"});
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit eh;
    int ep;
    rst_n = 1'b0; lk_page = '0; lk_sdid = '0; fill_valid = 1'b0;
    fill_page = '0; fill_sdid = '0; fill_span = '0; fill_perm = '0;
    fc_valid = 1'b0; fc_rs1_idx = '0; fc_rs2_idx = '0; fc_rs1_val = '0;
    fc_rs2_val = '0; fc_priv = 2'd3;
    for (int k = 0; k < N; k++) begin
      t_pn[k] = longint'(k) * (64'd1 << 18) + k;
      t_sd[k] = k % 3;
      t_sp[k] = k % 4;
      t_pm[k] = (k % 7) + 1;
    end
    // slot 7 nests inside slot 3 (1 GiB, domain 0): priority check
    t_pn[7] = 3 * (64'd1 << 18) + 5; t_sd[7] = 0; t_sp[7] = 0; t_pm[7] = 7;

    // R1 reset state
    do_reset();
    #1 chk(fc_illegal == 1'b0, "R1 illegal low", fc_illegal, 0);
    sweep("R1 reset");

    // R2 R3 R4 populated
    populate();
    sweep("R4 populated");
    look(t_pn[7], 0, "R2 R4 priority");

    // R5 + R10: x0 indices with garbage values
    do_fence(0, 64'hDEAD_BEEF_1234_5000, 0, 64'hFFFF_FFFF_FFFF_FFF3, 3, "R5");
    sweep("R5 R10 global");

    // R6 + R9: domain 1 with upper garbage
    do_reset(); populate();
    do_fence(0, 64'h3_0000_0000, 7, 64'hABCD_0000_FFF0_FFF1, 3, "R6");
    sweep("R6 R9 domain");

    // R7 inside 1 GiB entry of slot 3, all domains
    do_reset(); populate();
    do_fence(3, (longint'(t_pn[3]) << 12) + 64'h2345_6000, 0, 64'd2, 3, "R7");
    sweep("R7 addr");

    // R7 at the nested page: kills slot 7 and slot 3
    do_reset(); populate();
    do_fence(11, (longint'(t_pn[7]) << 12) + 64'hFFF, 0, 0, 3, "R7b");
    sweep("R7 nested");

    // R8 + R10: address in slot 3, domain 0 via value 0
    do_reset(); populate();
    do_fence(3, longint'(t_pn[3]) << 12, 4, 0, 3, "R8");
    sweep("R8 R10 both");

    // R8: address of slot 2 with wrong domain -> nothing dropped
    do_reset(); populate();
    do_fence(3, longint'(t_pn[2]) << 12, 4, 64'd1, 3, "R8b");
    sweep("R8 mismatch");
    // R13: the flushing variant saw the same fence
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      lk_page = PN_W'(t_pn[k]); lk_sdid = SL'(t_sd[k]);
      #1 chk(gf_hit == 1'b0, "R13 variant flushes all", gf_hit, 0);
    end

    // R10: non-zero index with value 0 -> address 0 (slot 0)
    do_reset(); populate();
    do_fence(9, 0, 0, 64'hFF, 3, "R10");
    sweep("R10 addr zero");

    // R11: below machine level
    do_reset(); populate();
    do_fence(0, 0, 0, 0, 1, "R11 s");
    do_fence(0, 0, 0, 0, 0, "R11 u");
    do_fence(3, longint'(t_pn[1]) << 12, 0, 0, 2, "R11 h");
    sweep("R11 no effect");

    // R12: same-cycle lookup and fill
    do_reset(); populate();
    @(negedge clk);
    fc_valid = 1'b1; fc_rs1_idx = 0; fc_rs2_idx = 6; fc_rs2_val = 64'd1; fc_priv = 2'd3;
    lk_page = PN_W'(t_pn[1]); lk_sdid = SL'(t_sd[1]);
    #1 chk(lk_hit == 1'b0, "R12 doomed lookup misses", lk_hit, 0);
    lk_page = PN_W'(t_pn[0]); lk_sdid = SL'(t_sd[0]);
    #1 chk(lk_hit == 1'b1, "R12 spared lookup hits", lk_hit, 1);
    @(posedge clk);
    model_fence(0, 0, 6, 1, 3);
    #1 fc_valid = 1'b0;
    @(negedge clk);
    fc_valid = 1'b1; fc_rs1_idx = 0; fc_rs2_idx = 0; fc_priv = 2'd3;
    fill_valid = 1'b1; fill_page = 22'h15_5555; fill_sdid = 4'd9;
    fill_span = 2'd0; fill_perm = 3'd5;
    @(posedge clk);
    model_fence(0, 0, 0, 0, 3);
    model_fill(64'h15_5555, 9, 0, 5);
    #1 begin fc_valid = 1'b0; fill_valid = 1'b0; end
    look(64'h15_5555, 9, "R12 fill survives");
    sweep("R12 after");

    // R4 wrap: ninth fill replaces slot 0
    do_reset(); populate();
    do_fill(64'h2A_0000, 3, 2, 6);
    expect_lookup(t_pn[0], t_sd[0], eh, ep);
    chk(eh == 1'b0, "R4 model wrap", eh, 0);
    look(t_pn[0], t_sd[0], "R4 wrap evicts slot0");
    look(64'h2A_0000, 3, "R4 wrap new");
    sweep("R4 wrap");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule